// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves byte-wide channels between serial time-division streams. A frame is a fixed run of channels, each eight bit periods long, sent most significant bit first, with one bit per clock. Every byte that arrives on any input stream is stored in a data memory. Each output stream and channel then takes its byte from a connection memory entry for that slot.

A connection memory entry has three parts: an enable bit, a mode bit and a payload. In switching mode the payload names an input stream and channel, and the byte sent is the one received in that slot during the previous frame. In message mode the payload byte itself is sent. A slot whose enable bit is clear sends all ones. A small synchronous processor port writes and reads the connection memory and reads the data memory, so that live channel data can be watched. Writes to the connection memory land in a shadow copy and take effect only at the next frame pulse.

A single frame pulse, shared by all streams, marks the first bit of channel 0. The default configuration has 4 streams of 32 channels, so a frame is 256 clocks.

Top module: `tsi_switch`

## Requirements
- R1: After reset and until the first frame pulse, every serial output is high. The processor read data is 0, and every connection memory entry reads back as 0, so every slot starts disabled.
- R2: An input bit `b` (0 = MSB) of channel `c` arrives in the clock cycle that is `8*c+b` cycles after the cycle in which `fsync_i` is high. The matching output bit appears on `ser_o` one clock later, and the outputs keep the same offset on every stream.
- R3: In switching mode (entry bit 8 = 0, bit 9 = 1), output stream `s` channel `c` carries the byte that input stream `payload[6:5]` channel `payload[4:0]` received during the previous frame. This gives a constant one-frame delay, and several outputs may name the same source.
- R4: In message mode (entry bit 8 = 1, bit 9 = 1), the output slot carries entry bits 7:0, whatever the input data.
- R5: When entry bit 9 (enable) is 0, the output slot is all ones in either mode.
- R6: A connection memory write made during a frame has no effect on that frame's outputs. It applies to every channel from the next frame pulse on.
- R7: A processor read with `cpu_sel_i` = 0 returns, on the next cycle, the last value written to that connection memory entry. A write with `cpu_sel_i` = 1 changes no connection memory entry.
- R8: A processor read with `cpu_sel_i` = 1 at address `{stream, channel}` returns, zero-extended on the next cycle, the byte that slot received in the most recently completed frame.
- R9: Data received in the last channel of a frame can be switched to channel 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| fsync_i | input | 1 | High in the cycle that carries the MSB of channel 0 |
| ser_i | input | NUM_STREAMS | Serial input streams |
| ser_o | output | NUM_STREAMS | Serial output streams, idle high |
| cpu_req_i | input | 1 | Processor access strobe |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_sel_i | input | 1 | 0 = connection memory, 1 = data memory (read only) |
| cpu_addr_i | input | SW+CW | Slot address {stream, channel} |
| cpu_wdata_i | input | ENT_W | Entry: bit 9 enable, bit 8 message mode, bits 7:0 payload |
| cpu_rdata_o | output | ENT_W | Read data, valid the cycle after the request |

## Verification
The hardest case to reach from the ports is a connection memory write whose effect has to wait for the next frame. Catching a design that applies it early needs writes issued in the middle of a frame that is being checked. It also needs expected bytes that are fixed at the frame pulse from the configuration in force at that moment. The stimulus therefore streams frames back to back and issues a full remapping during each checked frame, so any early commit corrupts that frame's comparison. The reversed mapping also sends the last channel's data into channel 0 of the next frame, which exercises the double-buffer turnover.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic {
        CM_SWITCH  = 1'b0,
        CM_MESSAGE = 1'b1
    } cm_mode_e;

    localparam logic [7:0] IDLE_BYTE   = 8'hFF;
    localparam int         BITS_PER_CH = 8;
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
    parameter int NUM_CH = 32,
    localparam int CW    = $clog2(NUM_CH),
    localparam int PW    = CW + 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fsync_i,
    output logic [2:0]    bit_o,
    output logic [CW-1:0] ch_o,
    output logic          frame_start_o,
    output logic          wr_bank_o,
    output logic          synced_o
);
    typedef struct packed {
        logic [PW-1:0] pos;
        logic          bank;
        logic          synced;
    } tmr_t;

    tmr_t st_d, st_q;

    // Position of the current cycle: a frame pulse forces slot 0, otherwise count on.
    always_comb begin
        st_d        = st_q;
        st_d.pos    = fsync_i ? '0 : st_q.pos + 1'b1;
        st_d.bank   = fsync_i ? ~st_q.bank : st_q.bank;
        st_d.synced = st_q.synced | fsync_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pos    <= '1;
            st_q.bank   <= 1'b0;
            st_q.synced <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o         = st_d.pos[2:0];
    assign ch_o          = st_d.pos[PW-1:3];
    assign frame_start_o = fsync_i;
    assign wr_bank_o     = st_d.bank;
    assign synced_o      = st_d.synced;
endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store #(
    parameter int NUM_STREAMS = 4,
    parameter int NUM_CH      = 32,
    localparam int SW         = $clog2(NUM_STREAMS),
    localparam int CW         = $clog2(NUM_CH),
    localparam int AW         = SW + CW,
    localparam int SLOTS      = NUM_STREAMS * NUM_CH,
    localparam int DEPTH      = 2 * SLOTS
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_STREAMS-1:0]    ser_i,
    input  logic [2:0]                bit_i,
    input  logic [CW-1:0]             ch_i,
    input  logic                      wr_bank_i,
    input  logic                      synced_i,
    input  logic [NUM_STREAMS*AW-1:0] tx_addr_i,
    output logic [NUM_STREAMS*8-1:0]  tx_data_o,
    input  logic [AW-1:0]             mon_addr_i,
    output logic [7:0]                mon_data_o
);
    typedef struct packed {
        logic [NUM_STREAMS-1:0][6:0] sh;
    } rx_t;

    rx_t        st_d, st_q;
    logic [7:0] mem_q [DEPTH];
    logic       wr_en;
    int         wr_idx  [NUM_STREAMS];
    logic [7:0] wr_byte [NUM_STREAMS];

    function automatic int slot_idx(input logic bank, input int addr);
        return (bank ? SLOTS : 0) + addr;
    endfunction

    assign wr_en = synced_i && (bit_i == 3'd7);

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_STREAMS; s++) begin
            st_d.sh[s] = {st_q.sh[s][5:0], ser_i[s]};
            wr_byte[s] = {st_q.sh[s], ser_i[s]};
            wr_idx[s]  = slot_idx(wr_bank_i, s * NUM_CH + int'(ch_i));
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Byte completes on bit 7; it goes to the half being filled this frame.
    always_ff @(posedge clk_i) begin
        if (rst_ni && wr_en) begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                mem_q[wr_idx[s]] <= wr_byte[s];
            end
        end
    end

    // Readers always see the half completed in the previous frame.
    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            tx_data_o[s*8 +: 8] = mem_q[slot_idx(~wr_bank_i, int'(tx_addr_i[s*AW +: AW]))];
        end
        mon_data_o = mem_q[slot_idx(~wr_bank_i, int'(mon_addr_i))];
    end

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_wr_chk
        assert_dm_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_en |=> mem_q[$past(wr_idx[g])] == $past(wr_byte[g]));
    end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter int NUM_STREAMS = 4,
    parameter int NUM_CH      = 32,
    parameter int ENT_W       = 10,
    localparam int SW         = $clog2(NUM_STREAMS),
    localparam int CW         = $clog2(NUM_CH),
    localparam int AW         = SW + CW,
    localparam int SLOTS      = NUM_STREAMS * NUM_CH
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         cpu_we_i,
    input  logic [AW-1:0]                cpu_addr_i,
    input  logic [ENT_W-1:0]             cpu_wdata_i,
    output logic [ENT_W-1:0]             cpu_rdata_o,
    input  logic                         frame_start_i,
    input  logic [CW-1:0]                ch_i,
    output logic [NUM_STREAMS*ENT_W-1:0] ent_o
);
    logic [ENT_W-1:0] shd_q [SLOTS];
    logic [ENT_W-1:0] act_q [SLOTS];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < SLOTS; i++) begin
                shd_q[i] <= '0;
                act_q[i] <= '0;
            end
        end else begin
            if (frame_start_i) begin
                for (int i = 0; i < SLOTS; i++) begin
                    act_q[i] <= shd_q[i];
                end
            end
            if (cpu_we_i) begin
                shd_q[cpu_addr_i] <= cpu_wdata_i;
            end
        end
    end

    assign cpu_rdata_o = shd_q[cpu_addr_i];

    // On the frame-start cycle the shadow copy is already the one in force.
    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            ent_o[s*ENT_W +: ENT_W] = frame_start_i ? shd_q[s * NUM_CH + int'(ch_i)]
                                                    : act_q[s * NUM_CH + int'(ch_i)];
        end
    end

    assert_commit_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_we_i && !frame_start_i) |=> act_q[$past(cpu_addr_i)] == $past(act_q[cpu_addr_i]));

    assert_shadow_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_we_i |=> shd_q[$past(cpu_addr_i)] == $past(cpu_wdata_i));
endmodule

// File: rtl/tsi_tx_serial.sv
module tsi_tx_serial #(
    parameter int NUM_STREAMS = 4,
    parameter int ENT_W       = 10,
    parameter int AW          = 7
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [2:0]                   bit_i,
    input  logic                         synced_i,
    input  logic [NUM_STREAMS*ENT_W-1:0] ent_i,
    output logic [NUM_STREAMS*AW-1:0]    dm_addr_o,
    input  logic [NUM_STREAMS*8-1:0]     dm_data_i,
    output logic [NUM_STREAMS-1:0]       ser_o
);
    import tsi_pkg::*;

    typedef struct packed {
        logic [NUM_STREAMS-1:0]      ser;
        logic [NUM_STREAMS-1:0][6:0] sh;
    } tx_t;

    tx_t                    st_d, st_q;
    logic                   load;
    logic [NUM_STREAMS-1:0] ent_oe;
    cm_mode_e               ent_mode [NUM_STREAMS];
    logic [7:0]             out_byte [NUM_STREAMS];

    assign load = synced_i && (bit_i == 3'd0);

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_STREAMS; s++) begin
            ent_oe[s]   = ent_i[s*ENT_W + ENT_W - 1];
            ent_mode[s] = cm_mode_e'(ent_i[s*ENT_W + ENT_W - 2]);
            dm_addr_o[s*AW +: AW] = ent_i[s*ENT_W +: AW];
            if (!ent_oe[s]) begin
                out_byte[s] = IDLE_BYTE;
            end else if (ent_mode[s] == CM_MESSAGE) begin
                out_byte[s] = ent_i[s*ENT_W +: 8];
            end else begin
                out_byte[s] = dm_data_i[s*8 +: 8];
            end
            if (load) begin
                st_d.ser[s] = out_byte[s][7];
                st_d.sh[s]  = out_byte[s][6:0];
            end else begin
                st_d.ser[s] = st_q.sh[s][6];
                st_d.sh[s]  = {st_q.sh[s][5:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.ser;

    assert_idle_unsynced_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !synced_i |-> (&ser_o));

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_oe_chk
        assert_disabled_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (load && !ent_oe[g]) |=> ser_o[g]);
    end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int NUM_STREAMS = 4,
    parameter int NUM_CH      = 32,
    localparam int SW         = $clog2(NUM_STREAMS),
    localparam int CW         = $clog2(NUM_CH),
    localparam int AW         = SW + CW,
    localparam int PAY_W      = (AW > 8) ? AW : 8,
    localparam int ENT_W      = PAY_W + 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   fsync_i,
    input  logic [NUM_STREAMS-1:0] ser_i,
    output logic [NUM_STREAMS-1:0] ser_o,
    input  logic                   cpu_req_i,
    input  logic                   cpu_we_i,
    input  logic                   cpu_sel_i,
    input  logic [AW-1:0]          cpu_addr_i,
    input  logic [ENT_W-1:0]       cpu_wdata_i,
    output logic [ENT_W-1:0]       cpu_rdata_o
);
    typedef struct packed {
        logic [ENT_W-1:0] rdata;
    } top_t;

    top_t                         st_d, st_q;
    logic [2:0]                   bit_w;
    logic [CW-1:0]                ch_w;
    logic                         fstart_w, wrbank_w, synced_w, cm_we_w;
    logic [NUM_STREAMS*ENT_W-1:0] ent_w;
    logic [NUM_STREAMS*AW-1:0]    dmaddr_w;
    logic [NUM_STREAMS*8-1:0]     dmdata_w;
    logic [ENT_W-1:0]             cm_rdata_w;
    logic [7:0]                   mon_data_w;

    assign cm_we_w = cpu_req_i && cpu_we_i && !cpu_sel_i;

    tsi_frame_timer #(.NUM_CH(NUM_CH)) u_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i),
        .bit_o(bit_w), .ch_o(ch_w), .frame_start_o(fstart_w),
        .wr_bank_o(wrbank_w), .synced_o(synced_w)
    );

    tsi_rx_store #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH)) u_rx (
        .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .bit_i(bit_w),
        .ch_i(ch_w), .wr_bank_i(wrbank_w), .synced_i(synced_w),
        .tx_addr_i(dmaddr_w), .tx_data_o(dmdata_w),
        .mon_addr_i(cpu_addr_i), .mon_data_o(mon_data_w)
    );

    tsi_conn_mem #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH), .ENT_W(ENT_W)) u_cmem (
        .clk_i(clk_i), .rst_ni(rst_ni), .cpu_we_i(cm_we_w),
        .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_rdata_o(cm_rdata_w), .frame_start_i(fstart_w),
        .ch_i(ch_w), .ent_o(ent_w)
    );

    tsi_tx_serial #(.NUM_STREAMS(NUM_STREAMS), .ENT_W(ENT_W), .AW(AW)) u_tx (
        .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_w), .synced_i(synced_w),
        .ent_i(ent_w), .dm_addr_o(dmaddr_w), .dm_data_i(dmdata_w),
        .ser_o(ser_o)
    );

    always_comb begin
        st_d = st_q;
        if (cpu_req_i && !cpu_we_i) begin
            st_d.rdata = cpu_sel_i ? {{(ENT_W-8){1'b0}}, mon_data_w} : cm_rdata_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rdata_o = st_q.rdata;
endmodule

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
    localparam int NS  = 4;
    localparam int NCH = 32;
    localparam int FRM = NCH * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic [NS-1:0] ser_i = '1;
    logic [NS-1:0] ser_o;
    logic          cpu_req = 1'b0, cpu_we = 1'b0, cpu_sel = 1'b0;
    logic [6:0]    cpu_addr = '0;
    logic [9:0]    cpu_wdata = '0;
    logic [9:0]    cpu_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [9:0] cfg     [NS][NCH];
    logic [7:0] in_cur  [NS][NCH];
    logic [7:0] in_prev [NS][NCH];
    logic [7:0] in_pp   [NS][NCH];
    logic [6:0] wq_addr [$];
    logic [9:0] wq_data [$];
    logic [7:0] exp_q   [$];
    bit         chk_q   [$];
    string      tag_q   [$];

    always #2 clk = ~clk;

    tsi_switch dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .ser_i(ser_i), .ser_o(ser_o),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_sel_i(cpu_sel),
        .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pattern(input int kind, input int s, input int c);
        return 8'((kind * 37 + s * 71 + c * 11) ^ (kind * c));
    endfunction

    function automatic logic [7:0] model_byte(input int s, input int c);
        logic [9:0] e;
        e = cfg[s][c];
        if (!e[9]) return 8'hFF;
        if (e[8]) return e[7:0];
        return in_prev[e[6:5]][e[4:0]];
    endfunction

    task automatic queue_write(input int s, input int c, input logic [9:0] d);
        wq_addr.push_back(7'(s * NCH + c));
        wq_data.push_back(d);
    endtask

    // Driver: one full frame, expected bytes frozen from the configuration at the pulse.
    task automatic run_frame(input int kind, input bit chk, input string tag);
        logic [7:0] exp_f [NS][NCH];
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NCH; c++) begin
                exp_f[s][c]  = model_byte(s, c);
                in_cur[s][c] = pattern(kind, s, c);
            end
        for (int i = 0; i < FRM; i++) begin
            @(negedge clk);
            fsync = (i == 0);
            for (int s = 0; s < NS; s++) ser_i[s] = in_cur[s][i / 8][7 - (i % 8)];
            if (i >= 2 && wq_addr.size() > 0) begin
                cpu_req = 1; cpu_we = 1; cpu_sel = 0;
                cpu_addr = wq_addr.pop_front();
                cpu_wdata = wq_data.pop_front();
                cfg[cpu_addr[6:5]][cpu_addr[4:0]] = cpu_wdata;
            end else begin
                cpu_req = 0; cpu_we = 0;
            end
            if (i == 1) begin
                for (int c = 0; c < NCH; c++)
                    for (int s = 0; s < NS; s++) begin
                        exp_q.push_back(exp_f[s][c]);
                        chk_q.push_back(chk);
                        tag_q.push_back(tag);
                    end
            end
        end
        in_pp   = in_prev;
        in_prev = in_cur;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fsync = 0; ser_i = '1; cpu_req = 0; cpu_we = 0;
        end
    endtask

    task automatic cpu_rd(input bit sel, input int addr, output logic [9:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_sel = sel; cpu_addr = 7'(addr);
        @(negedge clk);
        cpu_req = 0; cpu_sel = 0;
        d = cpu_rdata;
    endtask

    task automatic cpu_wr(input bit sel, input int addr, input logic [9:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_sel = sel; cpu_addr = 7'(addr); cpu_wdata = d;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0; cpu_sel = 0;
    endtask

    // Monitor: rebuilds bytes from the serial outputs and compares with the scoreboard.
    initial begin
        int         mpos;
        bit         msync;
        logic [7:0] acc [NS];
        mpos = 0; msync = 0;
        forever begin
            int p; bit sy;
            @(posedge clk);
            if (!rst_n) begin
                msync = 0; mpos = 0;
            end else if (fsync) begin
                mpos = 0; msync = 1;
            end else begin
                mpos = (mpos + 1) % FRM;
            end
            p = mpos; sy = msync;
            @(negedge clk);
            for (int s = 0; s < NS; s++) acc[s] = {acc[s][6:0], ser_o[s]};
            if (sy && (p % 8 == 7)) begin
                for (int s = 0; s < NS; s++) begin
                    if (exp_q.size() > 0) begin
                        logic [7:0] e; bit ck; string t;
                        e = exp_q.pop_front(); ck = chk_q.pop_front(); t = tag_q.pop_front();
                        if (ck) check($sformatf("%s R2 s%0d ch%0d", t, s, p / 8), {2'b0, acc[s]}, {2'b0, e});
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] d;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NCH; c++) begin
                cfg[s][c] = '0; in_prev[s][c] = '0; in_pp[s][c] = '0;
            end
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1: reset state before any frame pulse
        repeat (3) @(negedge clk);
        check("R1 idle outputs", {6'b0, ser_o}, {6'b0, 4'hF});
        check("R1 rdata after reset", cpu_rdata, 10'h000);
        cpu_rd(0, 37, d);
        check("R1 cmem reset entry", d, 10'h000);
        repeat (20) @(negedge clk);
        check("R1 still idle", {6'b0, ser_o}, {6'b0, 4'hF});

        // Frame A: reset config sends all ones; identity mapping queued mid-frame.
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NCH; c++) queue_write(s, c, {2'b10, 1'b0, 2'(s), 5'(c)});
        run_frame(1, 1, "R1 R5 R6");
        // Frame B: identity mapping in force; reversed mapping queued mid-frame.
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NCH; c++)
                queue_write(s, c, {2'b10, 1'b0, 2'(NS - 1 - s), 5'(NCH - 1 - c)});
        run_frame(2, 1, "R3 R6");
        // Frame C: reversed mapping, last channel lands in channel 0.
        for (int c = 0; c < NCH; c++) begin
            queue_write(0, c, {2'b10, 1'b0, 2'd2, 5'd5});
            queue_write(1, c, {2'b11, 8'(c * 7 + 3)});
            queue_write(2, c, (c % 2 == 0) ? {2'b01, 8'h00} : {2'b00, 1'b0, 2'd1, 5'(c)});
        end
        run_frame(3, 1, "R3 R9");
        // Frame D: broadcast, message bytes, disabled slots.
        run_frame(4, 1, "R3 R4 R5");
        run_frame(5, 1, "R4 R2");
        run_frame(6, 1, "R2");
        idle(12);

        // R8: monitor reads return the last completed frame (frame 5 data).
        for (int k = 0; k < 6; k++) begin
            int s, c;
            s = k % NS; c = (k * 13 + 31) % NCH;
            cpu_rd(1, s * NCH + c, d);
            check($sformatf("R8 dmem s%0d ch%0d", s, c), d, {2'b0, in_pp[s][c]});
        end
        cpu_rd(1, 3 * NCH + 31, d);
        check("R8 dmem last slot", d, {2'b0, in_pp[3][31]});

        // R7: connection memory readback and data-memory-select writes ignored.
        cpu_rd(0, 1 * NCH + 4, d);
        check("R7 cmem message entry", d, cfg[1][4]);
        cpu_rd(0, 2 * NCH + 3, d);
        check("R7 cmem disabled entry", d, cfg[2][3]);
        cpu_wr(1, 1 * NCH + 4, 10'h3FF);
        cpu_rd(0, 1 * NCH + 4, d);
        check("R7 sel=1 write ignored", d, cfg[1][4]);
        cpu_wr(0, 3 * NCH + 9, 10'h2C4);
        cpu_rd(0, 3 * NCH + 9, d);
        check("R7 cmem write readback", d, 10'h2C4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule